// File: doc/BRIEF.md
# Vector predicate mask generator

This block produces the per-lane activity mask used by a scalable-vector datapath. The datapath's register width is a run-time setting, given as a number of 128-bit granules, so a program cannot assume how many elements fit in one register. Software asks for a mask by giving an element size and a pattern. The pattern asks for either every element that fits, or a fixed number of leading elements. The block answers with one predicate bit per byte lane of the widest register.

Each byte lane has one bit in the predicate. For elements of E bytes, element k is reported in bit k*E, and the other bits of that E-byte group are zero. Suppose a fixed-count pattern asks for more elements than the configured register holds. The block then does not clamp the count. It returns a mask with every lane inactive, so later predicated work does nothing. The result is registered: one clock after a start strobe, the block gives a one-cycle valid pulse, and the mask stays unchanged until the next start.

Top module: `vpred_maskgen`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `start_i` high, and low in every other cycle.
- R2: Without a start, `pred_o` keeps its value from one cycle to the next.
- R3: Pattern code 0 makes the first (granules*16)>>size elements active, which is every element that fits in the register. Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword.
- R4: Pattern codes 1 to 8 ask for that many elements. Codes 9, 10, 11, 12 and 13 ask for 16, 32, 64, 128 and 256 elements. Counts are in elements of the selected size.
- R5: If a fixed count is larger than the number of elements that fit, the mask is all zero.
- R6: Element k sets bit k<<size, and every bit whose lane index is not a multiple of the element size in bytes is zero.
- R7: A granule count outside 1 to 16 gives an all-zero mask, and bits at lane granules*16 and above are always zero.
- R8: Pattern codes 14 and 15 give an all-zero mask.
- R9: While reset is applied, `pred_o` is all zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Strobe that samples the request |
| granules_i | input | 5 | Register width in 128-bit granules |
| esize_i | input | 2 | Element size code |
| pattern_i | input | 4 | Pattern code |
| pred_o | output | 256 | Predicate, one bit per byte lane |
| done_o | output | 1 | One-cycle result pulse |

## Verification
The assertions check on every cycle that the result pulse follows the strobe, that the mask holds between starts, that no bit appears off an element boundary or above the configured width, and that the unused pattern codes give an empty mask. The exact number of active elements cannot be shown by any of these properties. That includes the every-element count for each width and size, the fixed counts, and the all-inactive answer when a count does not fit. The bench's sweep over every granule count, size and pattern code, compared with a mask built by arithmetic, is the only check of those results.

// File: rtl/vpred_maskgen.sv
module vpred_maskgen #(
  parameter int GRAN_MAX   = 16,
  parameter int GRAN_BYTES = 16,
  localparam int LANES     = GRAN_MAX * GRAN_BYTES,
  localparam int GW        = $clog2(GRAN_MAX + 2),
  localparam int CW        = $clog2(LANES + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [GW-1:0]    granules_i,
  input  logic [1:0]       esize_i,
  input  logic [3:0]       pattern_i,
  output logic [LANES-1:0] pred_o,
  output logic             done_o
);

  logic             gran_ok;
  logic [CW-1:0]    reg_bytes, elems, req, active, low_bits;
  logic [LANES-1:0] pred_d;

  assign gran_ok   = (granules_i != '0) && (int'(granules_i) <= GRAN_MAX);
  assign reg_bytes = gran_ok ? CW'(granules_i) * CW'(GRAN_BYTES) : '0;
  assign elems     = reg_bytes >> esize_i;
  assign low_bits  = (CW'(1) << esize_i) - CW'(1);

  always_comb begin
    unique case (pattern_i)
      4'd0:                          req = elems;
      4'd1, 4'd2, 4'd3, 4'd4,
      4'd5, 4'd6, 4'd7, 4'd8:        req = CW'(pattern_i);
      4'd9, 4'd10, 4'd11, 4'd12,
      4'd13:                         req = CW'(16) << (pattern_i - 4'd9);
      default:                       req = '0;
    endcase
  end

  assign active = (req <= elems) ? req : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign pred_d[l] = ((CW'(l) & low_bits) == '0) && ((CW'(l) >> esize_i) < active);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) pred_o <= pred_d;
    end
  end

endmodule

module vpred_maskgen_chk #(
  parameter int GRAN_MAX   = 16,
  parameter int GRAN_BYTES = 16,
  localparam int LANES     = GRAN_MAX * GRAN_BYTES,
  localparam int GW        = $clog2(GRAN_MAX + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [GW-1:0]    granules_i,
  input logic [1:0]       esize_i,
  input logic [3:0]       pattern_i,
  input logic [LANES-1:0] pred_o,
  input logic             done_o
);

  function automatic logic [LANES-1:0] off_grid(input logic [1:0] es);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i % (1 << es)) != 0;
    return m;
  endfunction

  function automatic logic [LANES-1:0] above(input logic [GW-1:0] g);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = i >= int'(g) * GRAN_BYTES;
    return m;
  endfunction

  a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  a_r2_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(pred_o));
  a_r6_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pred_o & off_grid($past(esize_i))) == '0);
  a_r7_within_width: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pred_o & above($past(granules_i))) == '0);
  a_r8_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pattern_i >= 4'd14) |=> pred_o == '0);

endmodule

bind vpred_maskgen vpred_maskgen_chk #(.GRAN_MAX(GRAN_MAX), .GRAN_BYTES(GRAN_BYTES)) u_chk (.*);

// File: tb/test_vpred_maskgen.sv
module test_vpred_maskgen;
  localparam int LANES = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [4:0]       granules_i = '0;
  logic [1:0]       esize_i = '0;
  logic [3:0]       pattern_i = '0;
  logic [LANES-1:0] pred_o;
  logic             done_o;
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  vpred_maskgen i_vpred_maskgen (.*);

  function automatic logic [LANES-1:0] ref_mask(input int g, input int es, input int p);
    logic [LANES-1:0] m = '0;
    int bytes = (g >= 1 && g <= 16) ? g * 16 : 0;
    int elems = bytes / (1 << es);
    int n;
    if (p == 0)       n = elems;
    else if (p <= 8)  n = p;
    else if (p <= 13) n = 16 * (1 << (p - 9));
    else              n = 0;
    if (n > elems) n = 0;
    for (int k = 0; k < n; k++) m[k * (1 << es)] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset mask", pred_o, '0);
    check("R9 reset done", LANES'(done_o), '0);
    rst_n = 1'b1;
    for (int g = 0; g < 18; g++)
      for (int es = 0; es < 4; es++)
        for (int p = 0; p < 16; p++) begin
          logic [LANES-1:0] e;
          string tag;
          e = ref_mask(g, es, p);
          if (p >= 14)                tag = "R8 unused code";
          else if (g == 0 || g > 16)  tag = "R7 bad width";
          else if (p == 0)            tag = "R3 all pattern R6";
          else if (e == '0)           tag = "R5 oversize count";
          else                        tag = "R4 fixed count R6";
          @(negedge clk);
          granules_i = 5'(g); esize_i = 2'(es); pattern_i = 4'(p); start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
          granules_i = 5'(g + 3); pattern_i = 4'(p + 5);
          check(tag, pred_o, e);
          check("R1 done pulse", LANES'(done_o), LANES'(1));
          @(negedge clk);
          check("R2 hold", pred_o, e);
          check("R1 done drop", LANES'(done_o), '0);
        end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", pred_o, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule